// File: doc/BRIEF.md
# Seconds Counter RTC with Compare Alarm

This block is a real-time clock peripheral seen through a byte-wide register bus. It holds a 32-bit count of seconds that advances once per pulse of an external one-second tick while the clock is switched on. A prescaler or oscillator outside the block supplies that tick. Software sets a new time by staging the upper bytes first. The counter takes the whole value in one step when the lowest write byte is written. Software reads the running count back one byte at a time.

A 32-bit compare value is held beside the counter. When the alarm is armed and the count equals the compare value, the block raises a sticky flag and sends a single-cycle pulse on its interrupt output. Software clears the flag by writing zero to it. The read bytes show the live counter with no snapshot. A carry between two byte reads can therefore give a torn value. Software detects this by reading the low byte again and repeating the read when that byte has become smaller.

Top module: `rtc_sec_regs`

## Requirements
- R1: After reset the counter, the control byte, the alarm flag and `alarm_irq` are all 0. While control bit 7 is 0, tick pulses leave the counter unchanged.
- R2: While control bit 7 is 1, each clock cycle with `tick` high adds one to the counter. Cycles without `tick` leave it unchanged.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000.
- R4: A write to offset 0x3, 0x4 or 0x5 (staged bytes 1 to 3) does not change the counter. The written byte reads back from the same offset.
- R5: A write to offset 0x2 loads the counter at that clock edge with the staged bytes 3..1 above the written byte. A tick in the same cycle is overridden.
- R6: Offsets 0x6 to 0x9 return counter bytes 0 to 3, least significant byte at 0x6. The value is live, so a tick between two byte reads shows up in the later read.
- R7: Offsets 0xA to 0xD hold the alarm compare value, least significant byte at 0xA, and read back as written.
- R8: While control bit 1 is 1 and the counter equals the compare value, alarm-control bit 0 (offset 0x1) is set. `alarm_irq` is high for exactly one cycle, starting one cycle after the counter becomes equal, and does not pulse again while the match persists.
- R9: While control bit 1 is 0, an equal counter raises neither the flag nor `alarm_irq`.
- R10: Writing offset 0x1 with bit 0 = 0 clears the flag. Writing bit 0 = 1 leaves the flag unchanged. If a match is active in the same cycle, the flag stays set.
- R11: The control byte at offset 0x0 reads back only bits 7 and 1; all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| alarm_irq | output | 1 | Single-cycle rising-edge alarm pulse |

## Verification
The load-and-count behaviour is tried with four starting values, each followed by a given number of ticks. The value that needs no carry checks the byte order of the load. The values just below a byte boundary and below 0xFFFFFFFF check that a carry ripples through every byte and that the counter wraps. A tick placed in the same cycle as the commit write shows whether the load takes priority. A tick placed between byte reads shows the live, torn read. The alarm is tried armed and disarmed, with clear writes made both during and after the match. These separate the set-wins rule from an ordinary clear.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    // register offsets that software sequencing depends on
    localparam int OFS_CTRL  = 0;
    localparam int OFS_ACTL  = 1;
    localparam int OFS_STAGE = 2;
    localparam int OFS_LIVE  = 6;
    localparam int OFS_CMP   = 10;

    localparam int BIT_RUN  = 7;
    localparam int BIT_ARM  = 1;
    localparam int BIT_FLAG = 0;

    typedef struct packed {
        logic run;
        logic arm;
    } ctl_t;

    function automatic logic [7:0] ctl_to_byte(input ctl_t c);
        logic [7:0] b;
        b = '0;
        b[BIT_RUN] = c.run;
        b[BIT_ARM] = c.arm;
        return b;
    endfunction

    function automatic ctl_t byte_to_ctl(input logic [7:0] b);
        ctl_t c;
        c.run = b[BIT_RUN];
        c.arm = b[BIT_ARM];
        return c;
    endfunction

endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (load)
            count <= load_val;
        else if (run && tick)
            count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             clr_req,
    output logic             flag,
    output logic             irq
);
    logic hit;
    logic hit_d;

    always_comb hit = arm && (count == cmp_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            irq   <= 1'b0;
            hit_d <= 1'b0;
        end else begin
            hit_d <= hit;
            irq   <= hit && !hit_d;
            if (hit)
                flag <= 1'b1;
            else if (clr_req)
                flag <= 1'b0;
        end
    end
endmodule

// File: rtl/rtc_sec_regs.sv
module rtc_sec_regs
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              alarm_irq
);
    localparam int NBYTES = CNT_W / 8;

    ctl_t                   ctl_q;
    logic [NBYTES-1:0][7:0] stage_q;
    logic [NBYTES-1:0][7:0] cmp_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   flag_q;
    logic                   commit;
    logic                   clr_req;
    logic [CNT_W-1:0]       commit_val;

    always_comb begin
        commit     = wr_en && (addr == ADDR_W'(OFS_STAGE));
        clr_req    = wr_en && (addr == ADDR_W'(OFS_ACTL)) && !wdata[BIT_FLAG];
        commit_val = {stage_q[NBYTES-1:1], wdata};
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (wr_en && addr == ADDR_W'(OFS_CTRL))
            ctl_q <= byte_to_ctl(wdata);
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_bytes
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= '0;
                cmp_q[i]   <= '0;
            end else if (wr_en) begin
                if (addr == ADDR_W'(OFS_STAGE + i))
                    stage_q[i] <= wdata;
                if (addr == ADDR_W'(OFS_CMP + i))
                    cmp_q[i] <= wdata;
            end
        end
    end

    rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctl_q.run),
        .tick     (tick),
        .load     (commit),
        .load_val (commit_val),
        .count    (cnt_q)
    );

    rtc_sec_alarm #(.CNT_W(CNT_W)) u_alm (
        .clk     (clk),
        .rst     (rst),
        .arm     (ctl_q.arm),
        .count   (cnt_q),
        .cmp_val (cmp_q),
        .clr_req (clr_req),
        .flag    (flag_q),
        .irq     (alarm_irq)
    );

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_CTRL))
            rdata = ctl_to_byte(ctl_q);
        if (addr == ADDR_W'(OFS_ACTL))
            rdata[BIT_FLAG] = flag_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (addr == ADDR_W'(OFS_STAGE + i))
                rdata = stage_q[i];
            if (addr == ADDR_W'(OFS_LIVE + i))
                rdata = cnt_q[8*i +: 8];
            if (addr == ADDR_W'(OFS_CMP + i))
                rdata = cmp_q[i];
        end
    end
endmodule

// File: rtl/rtc_sec_chk.sv
module rtc_sec_chk
    import rtc_sec_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [CNT_W-1:0]  count,
    input logic              run,
    input logic              arm,
    input logic              flag,
    input logic              irq
);
    logic load;
    always_comb load = wr_en && (addr == ADDR_W'(OFS_STAGE));

    // R2 R3: one step per enabled tick, wrapping
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !load) |=> count == $past(count) + CNT_W'(1));

    // R1: halted counter holds
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!(run && tick) && !load) |=> count == $past(count));

    // R5: commit takes the written low byte
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        load |=> count[7:0] == $past(wdata));

    // R8: single-cycle pulse
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8: pulse coincides with a set flag
    a_r8_flag: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    // R9: disarmed alarm stays quiet
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !irq);
endmodule

bind rtc_sec_regs rtc_sec_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .count (cnt_q),
    .run   (ctl_q.run),
    .arm   (ctl_q.arm),
    .flag  (flag_q),
    .irq   (alarm_irq)
);

// File: tb/rtc_sec_regs_test.sv
module rtc_sec_regs_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       alarm_irq;

    int total = 0;
    int bad = 0;
    int irqs = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_sec_regs uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .alarm_irq(alarm_irq)
    );

    always @(negedge clk) if (!rst && alarm_irq) irqs++;

    // {load value, tick count, expected count}
    typedef struct packed {
        logic [31:0] ld;
        logic [7:0]  n;
        logic [31:0] exp_v;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{32'h1234_5678, 8'd0, 32'h1234_5678},
        '{32'h0000_00FE, 8'd3, 32'h0000_0101},
        '{32'h00FF_FFFF, 8'd1, 32'h0100_0000},
        '{32'hFFFF_FFFE, 8'd2, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd32(output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            rd(4'(6 + i), b);
            v[8*i +: 8] = b;
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load32(input logic [31:0] v);
        wr(4'h2, 8'h00);
        wr(4'h3, v[15:8]);
        wr(4'h4, v[23:16]);
        wr(4'h5, v[31:24]);
        wr(4'h2, v[7:0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  b;
        logic [7:0]  b0;
        logic [31:0] v;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and halted clock
        rd(4'h0, b); chk("R1 ctrl", 32'(b), 32'h00);
        rd(4'h1, b); chk("R1 flag", 32'(b), 32'h00);
        chk("R1 irq", 32'(alarm_irq), 32'h0);
        pulse_tick(); pulse_tick();
        rd32(v); chk("R1 halted count", v, 32'h0);

        // R11 control readback masks
        wr(4'h0, 8'h7D); rd(4'h0, b); chk("R11 ctrl 7D", 32'(b), 32'h00);
        wr(4'h0, 8'hFD); rd(4'h0, b); chk("R11 ctrl FD", 32'(b), 32'h80);
        wr(4'h0, 8'h00);

        // R5 R2 R3 table of load and count vectors
        foreach (VECS[k]) begin
            wr(4'h0, 8'h00);
            load32(VECS[k].ld);
            wr(4'h0, 8'h80);
            for (int t = 0; t < int'(VECS[k].n); t++) pulse_tick();
            wr(4'h0, 8'h00);
            rd32(v);
            chk($sformatf("R5 R2 R3 vec%0d", k), v, VECS[k].exp_v);
        end

        // R4 staged bytes do not touch the counter
        load32(32'h0102_0304);
        wr(4'h3, 8'hAA);
        wr(4'h5, 8'hBB);
        rd32(v); chk("R4 counter unchanged", v, 32'h0102_0304);
        rd(4'h3, b); chk("R4 stage1 readback", 32'(b), 32'hAA);
        rd(4'h5, b); chk("R4 stage3 readback", 32'(b), 32'hBB);

        // R5 commit wins over simultaneous tick
        load32(32'h0A0B_0C01);
        wr(4'h0, 8'h80);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h2; wdata = 8'h40; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd32(v); chk("R5 commit over tick", v, 32'h0A0B_0C40);

        // R3 wrap from all ones
        load32(32'hFFFF_FFFF);
        pulse_tick();
        rd32(v); chk("R3 wrap", v, 32'h0);

        // R6 live read tears across a carry
        load32(32'h0000_00FF);
        rd(4'h6, b0);
        pulse_tick();
        rd(4'h7, b); chk("R6 torn byte1", 32'(b), 32'h01);
        rd(4'h6, b); chk("R6 reread low smaller", 32'(b < b0), 32'h1);
        rd32(v); chk("R6 repeated read", v, 32'h0000_0100);

        // R7 compare bytes
        wr(4'h0, 8'h00);
        load32(32'h0000_0100);
        wr(4'hA, 8'h02); wr(4'hB, 8'h01); wr(4'hC, 8'h00); wr(4'hD, 8'h00);
        rd(4'hA, b); chk("R7 cmp byte0", 32'(b), 32'h02);
        rd(4'hB, b); chk("R7 cmp byte1", 32'(b), 32'h01);

        // R8 match pulse and sticky flag
        wr(4'h0, 8'h82);
        pulse_tick();
        rd(4'h1, b); chk("R8 no flag early", 32'(b), 32'h00);
        pulse_tick();
        chk("R8 irq not yet", 32'(alarm_irq), 32'h0);
        @(negedge clk); #1;
        chk("R8 irq high", 32'(alarm_irq), 32'h1);
        @(negedge clk); #1;
        chk("R8 irq one cycle", 32'(alarm_irq), 32'h0);
        repeat (4) @(negedge clk);
        rd(4'h1, b); chk("R8 flag set", 32'(b), 32'h01);
        chk("R8 single pulse", irqs, 1);

        // R10 clear rules
        wr(4'h1, 8'h00);
        rd(4'h1, b); chk("R10 set wins during match", 32'(b), 32'h01);
        pulse_tick();
        wr(4'h1, 8'h01);
        rd(4'h1, b); chk("R10 write one no effect", 32'(b), 32'h01);
        wr(4'h1, 8'hFE);
        rd(4'h1, b); chk("R10 clear", 32'(b), 32'h00);

        // R9 disarmed match
        wr(4'h0, 8'h80);
        wr(4'hA, 8'h04);
        pulse_tick();
        rd32(v); chk("R9 at compare", v, 32'h0000_0104);
        repeat (3) @(negedge clk);
        rd(4'h1, b); chk("R9 no flag", 32'(b), 32'h00);
        chk("R9 no irq", irqs, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule